// File: doc/BRIEF.md
# Debug Event Compare and Status Unit

This unit watches a processor pipeline for hardware debug events and turns them into an interrupt request. It receives an address for every completed instruction, an address with a read/write qualifier for every data access, and single-cycle strobes for taken branches and taken interrupts. Two instruction-address compare registers and two data-address compare registers each produce a breakpoint event on an exact address match. Each data comparator reports reads and writes as separate events, so each direction can be enabled on its own.

A control register holds one enable bit per event. Three more control bits are a global interrupt enable, a timer-freeze enable and a level select. An event is recorded in a sticky status register only when its enable bit is set. A status bit clears only when software writes a 1 to that bit position. While any status bit is set and the global enable is on, the unit raises an interrupt. The level select sends that interrupt either to a dedicated debug-level output or to the critical-level output. The freeze output stops timers while any event is recorded and freezing is enabled.

Software reaches the unit through one write port. A select value picks the target register, and the status bits can be read at all times on a dedicated output.

Top module: `dbg_evt_unit`

## Requirements
- R1: After reset, all compare registers, the control register and the status register are zero, and `dbg_irq`, `crit_irq` and `freeze` are low. With control at zero, no event is recorded.
- R2: When `ic_valid` is high and `ic_addr` equals instruction compare register i (write select i, i = 0..1), status bit i is set on the next clock edge, provided control bit i is set.
- R3: A data access with `da_valid` high whose `da_addr` equals data compare register j (write select 2+j) records an event on the next edge. A read (`da_write`=0) sets status bit 2+2j, and a write sets status bit 3+2j. The address match and the enable of the matching direction are both required.
- R4: Trace events are recorded on the next edge when enabled. `ic_valid` high sets status bit 6 (instruction complete). `br_taken` sets bit 7, and `irq_taken` sets bit 8.
- R5: An event whose control enable bit (bits 8..0 of the control register, write select 4) is clear never sets its status bit.
- R6: Status bits stay set until cleared. Writing select 5 clears exactly those status bits whose data bits are 1, and bits written as 0 keep their value.
- R7: If an enabled event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: While any status bit is set and control bit 9 (global interrupt enable) is set, an interrupt is raised. It goes on `dbg_irq` when control bit 11 is 1 and on `crit_irq` when bit 11 is 0. The two outputs are never high together, and both are low when bit 9 is clear or the status is zero.
- R9: `freeze` is high exactly when some status bit is set and control bit 10 is set.
- R10: With `ic_valid` or `da_valid` low, the corresponding address inputs produce no compare event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target: 0-1 instruction compare, 2-3 data compare, 4 control, 5 status clear |
| wr_data | input | 32 | Write data |
| ic_valid | input | 1 | An instruction completed this cycle |
| ic_addr | input | 32 | Address of the completed instruction |
| da_valid | input | 1 | A data access occurred this cycle |
| da_addr | input | 32 | Data access address |
| da_write | input | 1 | 1 for a write access, 0 for a read |
| br_taken | input | 1 | A branch was taken this cycle |
| irq_taken | input | 1 | An interrupt was taken this cycle |
| dbg_status | output | 9 | Sticky event status |
| dbg_irq | output | 1 | Interrupt request at the dedicated debug level |
| crit_irq | output | 1 | Interrupt request routed to the critical level |
| freeze | output | 1 | Timer freeze request |

## Verification
The assertions assume that the pipeline strobes and the write port are synchronous to `clk` and stable around the rising edge. They also assume that a status write and an event on the same bit may coincide, which R7 covers. The bench changes every input only on the falling edge and holds each stimulus for exactly one rising edge. It returns all strobes to zero before it samples the outputs. Write selects 6 and 7 are never used. Every input sequence therefore falls inside what the checker models.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

    function automatic int evt_count(int n_iac, int n_dac);
        return n_iac + 2 * n_dac + 3;
    endfunction

    function automatic int pos_dac_rd(int n_iac, int j);
        return n_iac + 2 * j;
    endfunction

    function automatic int pos_dac_wr(int n_iac, int j);
        return n_iac + 2 * j + 1;
    endfunction

    function automatic int pos_icmp(int n_iac, int n_dac);
        return n_iac + 2 * n_dac;
    endfunction

    function automatic int pos_brt(int n_iac, int n_dac);
        return n_iac + 2 * n_dac + 1;
    endfunction

    function automatic int pos_irqt(int n_iac, int n_dac);
        return n_iac + 2 * n_dac + 2;
    endfunction

endpackage

// File: rtl/dbg_evt_match.sv
module dbg_evt_match #(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              hit
);
    always_comb begin
        hit = valid && (addr == ref_addr);
    end
endmodule

// File: rtl/dbg_evt_regs.sv
module dbg_evt_regs
    import dbg_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_IAC  = 2,
    parameter int N_DAC  = 2,
    localparam int N_EVT  = evt_count(N_IAC, N_DAC),
    localparam int CTRL_W = N_EVT + 3,
    localparam int SEL_W  = $clog2(N_IAC + N_DAC + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [ADDR_W-1:0]            wr_data,
    input  logic [N_EVT-1:0]             evt,
    output logic [N_IAC-1:0][ADDR_W-1:0] iac_o,
    output logic [N_DAC-1:0][ADDR_W-1:0] dac_o,
    output logic [CTRL_W-1:0]            ctrl_o,
    output logic [N_EVT-1:0]             status_o
);
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(N_IAC + N_DAC);
    localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(N_IAC + N_DAC + 1);

    typedef struct packed {
        logic [N_IAC-1:0][ADDR_W-1:0] iac;
        logic [N_DAC-1:0][ADDR_W-1:0] dac;
        logic [CTRL_W-1:0]            ctrl;
        logic [N_EVT-1:0]             status;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic [N_EVT-1:0] clr_mask;
        st_d     = st_q;
        clr_mask = '0;
        if (wr_en) begin
            for (int i = 0; i < N_IAC; i++) begin
                if (wr_sel == SEL_W'(i)) st_d.iac[i] = wr_data;
            end
            for (int j = 0; j < N_DAC; j++) begin
                if (wr_sel == SEL_W'(N_IAC + j)) st_d.dac[j] = wr_data;
            end
            if (wr_sel == SEL_CTRL) st_d.ctrl = wr_data[CTRL_W-1:0];
            if (wr_sel == SEL_STAT) clr_mask = wr_data[N_EVT-1:0];
        end
        st_d.status = (st_q.status & ~clr_mask) | (evt & st_q.ctrl[N_EVT-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iac_o    = st_q.iac;
    assign dac_o    = st_q.dac;
    assign ctrl_o   = st_q.ctrl;
    assign status_o = st_q.status;
endmodule

// File: rtl/dbg_evt_unit.sv
module dbg_evt_unit
    import dbg_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_IAC  = 2,
    parameter int N_DAC  = 2,
    localparam int N_EVT  = evt_count(N_IAC, N_DAC),
    localparam int CTRL_W = N_EVT + 3,
    localparam int SEL_W  = $clog2(N_IAC + N_DAC + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              ic_valid,
    input  logic [ADDR_W-1:0] ic_addr,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic              da_write,
    input  logic              br_taken,
    input  logic              irq_taken,
    output logic [N_EVT-1:0]  dbg_status,
    output logic              dbg_irq,
    output logic              crit_irq,
    output logic              freeze
);
    localparam int B_GIE = N_EVT;
    localparam int B_FRZ = N_EVT + 1;
    localparam int B_LVL = N_EVT + 2;

    logic [N_IAC-1:0][ADDR_W-1:0] iac_w;
    logic [N_DAC-1:0][ADDR_W-1:0] dac_w;
    logic [CTRL_W-1:0]            ctrl_w;
    logic [N_EVT-1:0]             evt_w;
    logic [N_IAC-1:0]             iac_hit;
    logic [N_DAC-1:0]             dac_hit;

    for (genvar i = 0; i < N_IAC; i++) begin : g_iac
        dbg_evt_match #(.ADDR_W(ADDR_W)) u_match (
            .valid    (ic_valid),
            .addr     (ic_addr),
            .ref_addr (iac_w[i]),
            .hit      (iac_hit[i])
        );
        assign evt_w[i] = iac_hit[i];
    end

    for (genvar j = 0; j < N_DAC; j++) begin : g_dac
        dbg_evt_match #(.ADDR_W(ADDR_W)) u_match (
            .valid    (da_valid),
            .addr     (da_addr),
            .ref_addr (dac_w[j]),
            .hit      (dac_hit[j])
        );
        assign evt_w[pos_dac_rd(N_IAC, j)] = dac_hit[j] & ~da_write;
        assign evt_w[pos_dac_wr(N_IAC, j)] = dac_hit[j] &  da_write;
    end

    assign evt_w[pos_icmp(N_IAC, N_DAC)] = ic_valid;
    assign evt_w[pos_brt(N_IAC, N_DAC)]  = br_taken;
    assign evt_w[pos_irqt(N_IAC, N_DAC)] = irq_taken;

    dbg_evt_regs #(.ADDR_W(ADDR_W), .N_IAC(N_IAC), .N_DAC(N_DAC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .evt      (evt_w),
        .iac_o    (iac_w),
        .dac_o    (dac_w),
        .ctrl_o   (ctrl_w),
        .status_o (dbg_status)
    );

    logic any_evt, irq_req;
    always_comb begin
        any_evt  = |dbg_status;
        irq_req  = any_evt & ctrl_w[B_GIE];
        dbg_irq  = irq_req &  ctrl_w[B_LVL];
        crit_irq = irq_req & ~ctrl_w[B_LVL];
        freeze   = any_evt & ctrl_w[B_FRZ];
    end
endmodule

// File: rtl/dbg_evt_unit_chk.sv
module dbg_evt_unit_chk
    import dbg_evt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_IAC  = 2,
    parameter int N_DAC  = 2,
    localparam int N_EVT  = evt_count(N_IAC, N_DAC),
    localparam int CTRL_W = N_EVT + 3,
    localparam int SEL_W  = $clog2(N_IAC + N_DAC + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [ADDR_W-1:0] wr_data,
    input logic              br_taken,
    input logic [CTRL_W-1:0] ctrl,
    input logic [N_EVT-1:0]  status,
    input logic              dbg_irq,
    input logic              crit_irq,
    input logic              freeze
);
    localparam int P_BR = pos_brt(N_IAC, N_DAC);

    logic [N_EVT-1:0] clr_m;
    always_comb begin
        clr_m = (wr_en && wr_sel == SEL_W'(N_IAC + N_DAC + 1)) ? wr_data[N_EVT-1:0] : '0;
    end

    assert_branch_post_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && ctrl[P_BR]) |=> status[P_BR]);

    assert_gated_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status & ~$past(status)) & ~$past(ctrl[N_EVT-1:0])) == '0));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_m)) & ~status) == '0));

    assert_one_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_irq && crit_irq));

    assert_irq_needs_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_irq || crit_irq) |-> (status != '0));

    assert_freeze_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (status != '0));
endmodule

bind dbg_evt_unit dbg_evt_unit_chk #(.ADDR_W(ADDR_W), .N_IAC(N_IAC), .N_DAC(N_DAC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .br_taken (br_taken),
    .ctrl     (ctrl_w),
    .status   (dbg_status),
    .dbg_irq  (dbg_irq),
    .crit_irq (crit_irq),
    .freeze   (freeze)
);

// File: tb/dbg_evt_unit_bench.sv
`timescale 1ns/1ps
module dbg_evt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        ic_valid = 1'b0;
    logic [31:0] ic_addr = '0;
    logic        da_valid = 1'b0;
    logic [31:0] da_addr = '0;
    logic        da_write = 1'b0;
    logic        br_taken = 1'b0;
    logic        irq_taken = 1'b0;
    logic [8:0]  dbg_status;
    logic        dbg_irq, crit_irq, freeze;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dbg_evt_unit u_dbg_evt_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ic_valid(ic_valid), .ic_addr(ic_addr), .da_valid(da_valid), .da_addr(da_addr),
        .da_write(da_write), .br_taken(br_taken), .irq_taken(irq_taken),
        .dbg_status(dbg_status), .dbg_irq(dbg_irq), .crit_irq(crit_irq), .freeze(freeze)
    );

    typedef struct packed {
        logic        icv;
        logic [31:0] ica;
        logic        dav;
        logic [31:0] daa;
        logic        daw;
        logic        br;
        logic        it;
        logic [8:0]  exp;
    } vec_t;

    // Compare registers: IAC0=1000, IAC1=2000, DAC0=8000, DAC1=9000
    localparam vec_t TBL [10] = '{
        '{1'b1, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 9'h041}, // R2 IAC0 + R4 complete
        '{1'b1, 32'h2000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 9'h042}, // R2 IAC1
        '{1'b1, 32'h3000, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0, 9'h040}, // R4 complete only
        '{1'b0, 32'h0,    1'b1, 32'h8000, 1'b0, 1'b0, 1'b0, 9'h004}, // R3 DAC0 read
        '{1'b0, 32'h0,    1'b1, 32'h8000, 1'b1, 1'b0, 1'b0, 9'h008}, // R3 DAC0 write
        '{1'b0, 32'h0,    1'b1, 32'h9000, 1'b0, 1'b0, 1'b0, 9'h010}, // R3 DAC1 read
        '{1'b0, 32'h0,    1'b1, 32'h9000, 1'b1, 1'b0, 1'b0, 9'h020}, // R3 DAC1 write
        '{1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1, 1'b1, 9'h180}, // R4 branch + interrupt
        '{1'b0, 32'h1000, 1'b0, 32'h8000, 1'b0, 1'b0, 1'b0, 9'h000}, // R10 no valid
        '{1'b1, 32'h1000, 1'b1, 32'h9000, 1'b1, 1'b1, 1'b0, 9'h0E1}  // R2 R3 R4 combined
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle_inputs();
        ic_valid = 1'b0; ic_addr = '0; da_valid = 1'b0; da_addr = '0;
        da_write = 1'b0; br_taken = 1'b0; irq_taken = 1'b0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        ic_valid = v.icv; ic_addr = v.ica; da_valid = v.dav; da_addr = v.daa;
        da_write = v.daw; br_taken = v.br; irq_taken = v.it;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(dbg_status), 32'h0);
        chk("R1 irq/crit/freeze", {29'b0, dbg_irq, crit_irq, freeze}, 32'h0);
        apply('{1'b1, 32'h0, 1'b1, 32'h0, 1'b1, 1'b1, 1'b1, 9'h0});
        chk("R1 no post with ctrl zero", 32'(dbg_status), 32'h0);

        wr(3'd0, 32'h1000);
        wr(3'd1, 32'h2000);
        wr(3'd2, 32'h8000);
        wr(3'd3, 32'h9000);
        wr(3'd4, 32'hFFF);

        for (int k = 0; k < 10; k++) begin
            wr(3'd5, 32'h1FF);
            apply(TBL[k]);
            chk($sformatf("R2/R3/R4/R10 vector %0d", k), 32'(dbg_status), 32'(TBL[k].exp));
        end

        // R5 disabled events not posted
        wr(3'd5, 32'h1FF);
        wr(3'd4, 32'h201);
        apply('{1'b1, 32'h1000, 1'b1, 32'h8000, 1'b1, 1'b1, 1'b1, 9'h0});
        chk("R5 only enabled bit", 32'(dbg_status), 32'h001);

        // R6 sticky and write-one-to-clear
        @(negedge clk);
        chk("R6 sticky", 32'(dbg_status), 32'h001);
        wr(3'd5, 32'h1FE);
        chk("R6 zero bits keep", 32'(dbg_status), 32'h001);
        wr(3'd5, 32'h001);
        chk("R6 clear", 32'(dbg_status), 32'h000);

        // R7 set wins over clear in the same cycle
        wr(3'd4, 32'h080);
        @(negedge clk);
        br_taken = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 32'h080;
        @(negedge clk);
        br_taken = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R7 set over clear", 32'(dbg_status), 32'h080);

        // R8 level routing and global enable
        chk("R8 gie off", {30'b0, dbg_irq, crit_irq}, 32'h0);
        wr(3'd4, 32'hA80);
        chk("R8 debug level", {30'b0, dbg_irq, crit_irq}, 32'h2);
        wr(3'd4, 32'h280);
        chk("R8 critical level", {30'b0, dbg_irq, crit_irq}, 32'h1);

        // R9 freeze
        chk("R9 freeze off", 32'(freeze), 32'h0);
        wr(3'd4, 32'h680);
        chk("R9 freeze on", 32'(freeze), 32'h1);
        wr(3'd5, 32'h1FF);
        chk("R9 freeze drops with status", 32'(freeze), 32'h0);
        chk("R8 no irq without status", {30'b0, dbg_irq, crit_irq}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule